// File: doc/BRIEF.md
# Masked Vector Execution Sequencer

The sequencer drives one pipelined integer arithmetic unit through the elements of a single vector-register operation. A start command carries an opcode, a destination and two source register numbers, a scalar operand and a masking flag. Once the command is taken, the sequencer issues one element per clock into a fixed-latency pipeline. Results return in order and are written to the destination register one element at a time. A compare operation writes its per-element outcome into the mask register and leaves the vector registers alone.

Each of the eight vector registers has a "written up to" counter that is visible on a port. An operation that names a register as its destination clears that register's counter to zero when it starts. Each retired element then adds one. A separate fill stream lets an outside producer, such as a load path, write a register in element order, and it advances the same counter. The sequencer reads a source element only after that source's counter has passed the element's index. Because of this, an operation can chain behind a producer element by element and does not have to wait for the whole vector.

Start commands use a valid/ready handshake: `cmd_ready` is high only while the unit is idle, and a command held while the unit is busy waits. Fill beats also use valid/ready, and the register-file write port gives priority to result writeback. The mask, the vector length, the counters and the peek read port are plain control and status pins.

Top module: `vmask_seq`

## Requirements
- R1: A write to the length register stores the value given, except that any value above 64 is stored as 64; `vl_o` shows the stored value.
- R2: `cmd_ready` is high only while idle. A command presented while the unit is busy is neither taken nor run later, and it produces no second `done`.
- R3: For each element i below the length: opcode 0 writes src1[i]+src2[i], opcode 1 writes src1[i]+scalar, and opcode 2 writes the low 16 bits of src1[i]*src2[i], all into dst[i]. Elements at or above the length keep their old values.
- R4: Opcode 3 sets mask bit i to (src1[i]==src2[i]) for each i below the length. It leaves the other mask bits, every vector register and every counter unchanged, and it ignores the masking flag.
- R5: When `cmd_masked` is 1, an element whose mask bit is 0 is not written but still uses its issue slot.
- R6: With no stall, one element issues per clock, and `done` is high for one cycle exactly length+6 edges after the accepting edge for opcodes 0, 1 and 3, and length+7 edges after it for opcode 2.
- R7: A length of zero writes nothing and raises `done` one edge after the accepting edge.
- R8: The destination counter reads 0 after acceptance and counts every retired element, masked or not, up to the length. After reset every counter reads 64.
- R9: Element i does not issue until each vector source other than the destination shows a counter above i. A chained result is correct, and `done` stays low while the source is incomplete.
- R10: A fill beat with `fill_first` set writes element 0 and sets the register's counter to 1. Any other beat writes at the current counter value and then increments it. `fill_ready` is low in any cycle in which a result writes the register file.
- R11: After reset `cmd_ready` is 1, `done` is 0, the mask is all ones and the length is 64.
- R12: A source that is also the destination never stalls issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start command offered |
| cmd_ready | output | 1 | Unit idle, command taken when valid |
| cmd_op | input | 2 | 0 add vv, 1 add vs, 2 mul vv, 3 compare-equal |
| cmd_masked | input | 1 | Apply the mask to writes |
| cmd_vd | input | 3 | Destination register |
| cmd_vs1 | input | 3 | First source register |
| cmd_vs2 | input | 3 | Second source register |
| cmd_scalar | input | 16 | Scalar operand for opcode 1 |
| done | output | 1 | One-cycle completion pulse |
| vl_wr | input | 1 | Load the length register |
| vl_in | input | 8 | New length (clamped) |
| vl_o | output | 7 | Current length |
| mask_wr | input | 1 | Load the mask register |
| mask_in | input | 64 | New mask |
| mask_o | output | 64 | Current mask |
| fill_valid | input | 1 | Fill beat offered |
| fill_ready | output | 1 | Fill beat taken when valid |
| fill_first | input | 1 | Beat is element 0 of a new fill |
| fill_reg | input | 3 | Register being filled |
| fill_data | input | 16 | Element value |
| upto_o | output | 56 | Eight 7-bit written-up-to counters, register r at bits r*7 |
| peek_reg | input | 3 | Read-port register |
| peek_idx | input | 6 | Read-port element |
| peek_data | output | 16 | Element value, combinational |

## Verification
The bench measures completion latency to the exact edge for every opcode and for a zero length. A pipeline tap that is off by one, or a zero length that waits on the pipeline, would move `done` by a cycle. It checks every element of the destination, so a design that wrote past the length or wrote masked elements would corrupt elements that should have kept their old values. It runs a chained add behind a fill that is only partly done. A design that read the source early would finish early and produce wrong sums, and one that wrongly stalled when a source is also the destination would miss its latency. It also holds a second command against a busy unit, where a design that latched that command would change a register the bench expects to keep its old value.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;
  localparam int NREG  = 8;
  localparam int VLMAX = 64;
  localparam int DW    = 16;
  localparam int RW    = $clog2(NREG);
  localparam int IW    = $clog2(VLMAX);
  localparam int CW    = $clog2(VLMAX + 1);
  localparam int AW    = RW + IW;

  typedef enum logic [1:0] {
    OP_ADD_VV = 2'd0,
    OP_ADD_VS = 2'd1,
    OP_MUL_VV = 2'd2,
    OP_CMP_EQ = 2'd3
  } vop_e;

  typedef struct packed {
    logic          valid;
    logic          long_lat;
    logic          wr_en;
    logic          is_cmp;
    logic [RW-1:0] dst;
    logic [IW-1:0] idx;
    logic [DW-1:0] data;
  } velem_t;
endpackage

// File: rtl/vseq_rf.sv
`timescale 1ns/1ps
module vseq_rf
  import vseq_pkg::*;
#(
  parameter int NRP = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRP],
  output logic [DW-1:0] rdata [NRP]
);
  logic [DW-1:0] mem [NREG*VLMAX];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/vseq_pipe.sv
`timescale 1ns/1ps
module vseq_pipe
  import vseq_pkg::*;
#(
  parameter int ADD_LAT = 6,
  parameter int MUL_LAT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  vop_e          iss_op,
  input  logic [DW-1:0] iss_a,
  input  logic [DW-1:0] iss_b,
  input  logic          iss_wr_en,
  input  logic [RW-1:0] iss_dst,
  input  logic [IW-1:0] iss_idx,
  output velem_t        out_e
);
  velem_t st [MUL_LAT];
  velem_t head;
  logic [DW-1:0] res;

  always_comb begin
    unique case (iss_op)
      OP_ADD_VV, OP_ADD_VS: res = iss_a + iss_b;
      OP_MUL_VV:            res = iss_a * iss_b;
      default:              res = {{(DW-1){1'b0}}, iss_a == iss_b};
    endcase
    head.valid    = iss_valid;
    head.long_lat = (iss_op == OP_MUL_VV);
    head.wr_en    = iss_wr_en;
    head.is_cmp   = (iss_op == OP_CMP_EQ);
    head.dst      = iss_dst;
    head.idx      = iss_idx;
    head.data     = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= head;
  end

  for (genvar k = 1; k < MUL_LAT; k++) begin : g_st
    if (k == ADD_LAT) begin : g_drop
      velem_t nxt;
      always_comb begin
        nxt       = st[k-1];
        nxt.valid = st[k-1].valid & st[k-1].long_lat;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[k] <= '0;
        else        st[k] <= nxt;
      end
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[k] <= '0;
        else        st[k] <= st[k-1];
      end
    end
  end

  logic short_hit, long_hit;
  assign short_hit = st[ADD_LAT-1].valid && !st[ADD_LAT-1].long_lat;
  assign long_hit  = st[MUL_LAT-1].valid &&  st[MUL_LAT-1].long_lat;

  always_comb begin
    if (short_hit)     out_e = st[ADD_LAT-1];
    else if (long_hit) out_e = st[MUL_LAT-1];
    else               out_e = '0;
  end

  // R6
  single_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_hit && long_hit));
endmodule

// File: rtl/vseq_ctrl.sv
`timescale 1ns/1ps
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MUL_LAT = 7,
  parameter int VLIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_masked,
  input  logic [RW-1:0]     cmd_vd,
  input  logic [RW-1:0]     cmd_vs1,
  input  logic [RW-1:0]     cmd_vs2,
  input  logic [DW-1:0]     cmd_scalar,
  output logic              done,
  input  logic              vl_wr,
  input  logic [VLIN_W-1:0] vl_in,
  output logic [CW-1:0]     vl_o,
  input  logic              mask_wr,
  input  logic [VLMAX-1:0]  mask_in,
  output logic [VLMAX-1:0]  mask_o,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_first,
  input  logic [RW-1:0]     fill_reg,
  input  logic [DW-1:0]     fill_data,
  output logic [NREG*CW-1:0] upto_o,
  output logic [AW-1:0]     rd_addr_a,
  output logic [AW-1:0]     rd_addr_b,
  input  logic [DW-1:0]     rd_data_a,
  input  logic [DW-1:0]     rd_data_b,
  output logic              iss_valid,
  output vop_e              iss_op,
  output logic [DW-1:0]     iss_a,
  output logic [DW-1:0]     iss_b,
  output logic              iss_wr_en,
  output logic [RW-1:0]     iss_dst,
  output logic [IW-1:0]     iss_idx_o,
  input  velem_t            ret_e,
  output logic              rf_we,
  output logic [AW-1:0]     rf_waddr,
  output logic [DW-1:0]     rf_wdata
);
  localparam int FW = $clog2(MUL_LAT + 2);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e           state;
  vop_e          op_q, cmd_op_e;
  logic          masked_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [DW-1:0] scal_q;
  logic [CW-1:0] vlen_q, vl_q, iss_idx;
  logic [FW-1:0] inflight;
  logic [VLMAX-1:0] mask_q;
  logic [CW-1:0] upto [NREG];

  logic accept, issue, retire, last, a_ok, b_ok, wb_w, fill_fire, fill_ok;
  logic [CW-1:0] fill_idx;

  assign cmd_op_e  = vop_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign retire    = ret_e.valid;
  assign vl_o      = vl_q;
  assign mask_o    = mask_q;

  // source readiness: a source that is also the destination is read before its own write
  assign a_ok = ((op_q != OP_CMP_EQ) && (vs1_q == vd_q)) || (upto[vs1_q] > iss_idx);
  assign b_ok = (op_q == OP_ADD_VS) || ((op_q != OP_CMP_EQ) && (vs2_q == vd_q)) ||
                (upto[vs2_q] > iss_idx);
  assign issue = (state == ST_RUN) && (iss_idx < vlen_q) && a_ok && b_ok;
  assign last  = (state == ST_RUN) && (iss_idx == vlen_q) &&
                 ((inflight == '0) || ((inflight == FW'(1)) && retire));

  assign rd_addr_a = {vs1_q, iss_idx[IW-1:0]};
  assign rd_addr_b = {vs2_q, iss_idx[IW-1:0]};
  assign iss_valid = issue;
  assign iss_op    = op_q;
  assign iss_a     = rd_data_a;
  assign iss_b     = (op_q == OP_ADD_VS) ? scal_q : rd_data_b;
  assign iss_wr_en = !masked_q || mask_q[iss_idx[IW-1:0]];
  assign iss_dst   = vd_q;
  assign iss_idx_o = iss_idx[IW-1:0];

  // register-file write port: writeback first, fill stream second
  assign wb_w       = retire && ret_e.wr_en && !ret_e.is_cmp;
  assign fill_ready = !wb_w;
  assign fill_fire  = fill_valid && fill_ready;
  assign fill_idx   = fill_first ? '0 : upto[fill_reg];
  assign fill_ok    = fill_first || (upto[fill_reg] < CW'(VLMAX));
  assign rf_we      = wb_w || (fill_fire && fill_ok);
  assign rf_waddr   = wb_w ? {ret_e.dst, ret_e.idx} : {fill_reg, fill_idx[IW-1:0]};
  assign rf_wdata   = wb_w ? ret_e.data : fill_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_ADD_VV;
      masked_q <= 1'b0;
      vd_q     <= '0;
      vs1_q    <= '0;
      vs2_q    <= '0;
      scal_q   <= '0;
      vlen_q   <= '0;
      iss_idx  <= '0;
      inflight <= '0;
      done     <= 1'b0;
    end else begin
      done     <= last;
      inflight <= inflight + FW'(issue) - FW'(retire);
      if (issue) iss_idx <= iss_idx + 1'b1;
      if (accept) begin
        state    <= ST_RUN;
        op_q     <= cmd_op_e;
        masked_q <= cmd_masked;
        vd_q     <= cmd_vd;
        vs1_q    <= cmd_vs1;
        vs2_q    <= cmd_vs2;
        scal_q   <= cmd_scalar;
        vlen_q   <= vl_q;
        iss_idx  <= '0;
      end else if (last) begin
        state <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= CW'(VLMAX);
      mask_q <= '1;
    end else begin
      if (vl_wr) vl_q <= (vl_in > VLIN_W'(VLMAX)) ? CW'(VLMAX) : vl_in[CW-1:0];
      if (retire && ret_e.is_cmp) mask_q[ret_e.idx] <= ret_e.data[0];
      else if (mask_wr)           mask_q <= mask_in;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        upto[r] <= CW'(VLMAX);
      else if (accept && (cmd_op_e != OP_CMP_EQ) && (cmd_vd == RW'(r)))
        upto[r] <= '0;
      else if (fill_fire && fill_ok && (fill_reg == RW'(r)))
        upto[r] <= fill_first ? CW'(1) : upto[r] + 1'b1;
      else if (retire && !ret_e.is_cmp && (ret_e.dst == RW'(r)))
        upto[r] <= upto[r] + 1'b1;
    end
    assign upto_o[r*CW +: CW] = upto[r];
  end

  // R1
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= CW'(VLMAX));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(op_q) && $stable(vd_q) && $stable(vlen_q)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  ret_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> ((state == ST_RUN) && (CW'(ret_e.idx) < vlen_q)));
  // R6
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= FW'(MUL_LAT));
endmodule

// File: rtl/vmask_seq.sv
`timescale 1ns/1ps
module vmask_seq
  import vseq_pkg::*;
#(
  parameter int ADD_LAT = 6,
  parameter int MUL_LAT = 7,
  parameter int VLIN_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_masked,
  input  logic [RW-1:0]      cmd_vd,
  input  logic [RW-1:0]      cmd_vs1,
  input  logic [RW-1:0]      cmd_vs2,
  input  logic [DW-1:0]      cmd_scalar,
  output logic               done,
  input  logic               vl_wr,
  input  logic [VLIN_W-1:0]  vl_in,
  output logic [CW-1:0]      vl_o,
  input  logic               mask_wr,
  input  logic [VLMAX-1:0]   mask_in,
  output logic [VLMAX-1:0]   mask_o,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic               fill_first,
  input  logic [RW-1:0]      fill_reg,
  input  logic [DW-1:0]      fill_data,
  output logic [NREG*CW-1:0] upto_o,
  input  logic [RW-1:0]      peek_reg,
  input  logic [IW-1:0]      peek_idx,
  output logic [DW-1:0]      peek_data
);
  logic [AW-1:0] raddr [3];
  logic [DW-1:0] rdata [3];
  logic          rf_we, iss_valid, iss_wr_en;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, iss_a, iss_b;
  vop_e          iss_op;
  logic [RW-1:0] iss_dst;
  logic [IW-1:0] iss_idx;
  velem_t        ret_e;

  assign raddr[2]  = {peek_reg, peek_idx};
  assign peek_data = rdata[2];

  vseq_ctrl #(.MUL_LAT(MUL_LAT), .VLIN_W(VLIN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_masked(cmd_masked), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
    .cmd_scalar(cmd_scalar), .done(done),
    .vl_wr(vl_wr), .vl_in(vl_in), .vl_o(vl_o),
    .mask_wr(mask_wr), .mask_in(mask_in), .mask_o(mask_o),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_first(fill_first),
    .fill_reg(fill_reg), .fill_data(fill_data), .upto_o(upto_o),
    .rd_addr_a(raddr[0]), .rd_addr_b(raddr[1]),
    .rd_data_a(rdata[0]), .rd_data_b(rdata[1]),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .iss_wr_en(iss_wr_en), .iss_dst(iss_dst), .iss_idx_o(iss_idx),
    .ret_e(ret_e),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  vseq_pipe #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .iss_wr_en(iss_wr_en), .iss_dst(iss_dst), .iss_idx(iss_idx),
    .out_e(ret_e)
  );

  vseq_rf #(.NRP(3)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/vmask_seq_bench.sv
`timescale 1ns/1ps
module vmask_seq_bench;
  import vseq_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_masked, done, vl_wr, mask_wr;
  logic [1:0] cmd_op;
  logic [2:0] cmd_vd, cmd_vs1, cmd_vs2, fill_reg, peek_reg;
  logic [15:0] cmd_scalar, fill_data, peek_data;
  logic [7:0] vl_in;
  logic [6:0] vl_o;
  logic [63:0] mask_in, mask_o;
  logic fill_valid, fill_ready, fill_first;
  logic [55:0] upto_o;
  logic [5:0] peek_idx;

  vmask_seq u_vmask_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_masked(cmd_masked), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1),
    .cmd_vs2(cmd_vs2), .cmd_scalar(cmd_scalar), .done(done),
    .vl_wr(vl_wr), .vl_in(vl_in), .vl_o(vl_o),
    .mask_wr(mask_wr), .mask_in(mask_in), .mask_o(mask_o),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_first(fill_first),
    .fill_reg(fill_reg), .fill_data(fill_data), .upto_o(upto_o),
    .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data)
  );

  typedef struct { int r; int i; logic [15:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [15:0] model [8][64];
  logic [63:0] mask_ref;
  int cur_vl;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit drain_req = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int upto_of(int r);
    return int'(upto_o[r*7 +: 7]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // monitor: pops expected elements and compares them through the peek port
  initial begin
    exp_t e;
    peek_reg = 0; peek_idx = 0;
    forever begin
      @(negedge clk);
      if (drain_req) begin
        while (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          peek_reg = 3'(e.r); peek_idx = 6'(e.i);
          #0.1;
          chk(peek_data == e.v, e.tag, peek_data, e.v);
        end
        drain_req = 0;
      end
    end
  end

  task automatic fill_one(int r, int idx, logic [15:0] d);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      fill_valid = 1; fill_reg = 3'(r); fill_first = (idx == 0); fill_data = d;
      acc = fill_ready;
      @(posedge clk);
    end
    @(negedge clk);
    fill_valid = 0;
    model[r][idx] = d;
  endtask

  task automatic fill_vec(int r, int base, int step);
    for (int i = 0; i < 64; i++) fill_one(r, i, 16'(base + i * step));
  endtask

  task automatic set_vl(int v);
    @(negedge clk); vl_wr = 1; vl_in = 8'(v);
    @(negedge clk); vl_wr = 0;
    cur_vl = (v > 64) ? 64 : v;
  endtask

  // driver: computes expectations, queues them, runs the command
  task automatic predict(int op, bit msk, int vd, int vs1, int vs2, logic [15:0] sc, string tag);
    logic [15:0] a, b, r;
    for (int i = 0; i < cur_vl; i++) begin
      a = model[vs1][i];
      b = (op == 1) ? sc : model[vs2][i];
      r = (op == 2) ? 16'(a * b) : 16'(a + b);
      if (op == 3) mask_ref[i] = (a == b);
      else if (!msk || mask_ref[i]) model[vd][i] = r;
    end
    if (op != 3)
      for (int i = 0; i < 64; i++) exp_q.push_back('{vd, i, model[vd][i], tag});
  endtask

  task automatic start_cmd(int op, bit msk, int vd, int vs1, int vs2, logic [15:0] sc);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_masked = msk; cmd_vd = 3'(vd);
    cmd_vs1 = 3'(vs1); cmd_vs2 = 3'(vs2); cmd_scalar = sc;
    chk(cmd_ready == 1, "R2 ready when idle", cmd_ready, 1);
    @(posedge clk);
  endtask

  task automatic drain();
    drain_req = 1;
    wait (!drain_req);
  endtask

  task automatic run_op(int op, bit msk, int vd, int vs1, int vs2, logic [15:0] sc,
                        int exp_lat, string tag, bit probe);
    int cnt = 0;
    predict(op, msk, vd, vs1, vs2, sc, tag);
    start_cmd(op, msk, vd, vs1, vs2, sc);
    @(negedge clk);
    if (probe) begin
      cmd_valid = 1; cmd_op = 2'd2;
    end else cmd_valid = 0;
    forever begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (probe && cnt <= 5) chk(cmd_ready == 0, "R2 busy refuses", cmd_ready, 0);
      if (probe && cnt == 5) cmd_valid = 0;
      if (probe && cnt == 3) chk(fill_ready == 1, "R10 fill open", fill_ready, 1);
      if (probe && cnt == 10) chk(fill_ready == 0, "R10 fill blocked by writeback", fill_ready, 0);
      if (done || cnt > 2000) break;
    end
    chk(cnt == exp_lat, {tag, " R6 latency"}, cnt, exp_lat);
    if (probe) begin
      bit extra = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (done) extra = 1;
      end
      chk(!extra, "R2 no second done", extra, 0);
    end
    drain();
  endtask

  initial begin
    int cnt;
    bit early;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_masked = 0; cmd_vd = 0; cmd_vs1 = 0;
    cmd_vs2 = 0; cmd_scalar = 0; vl_wr = 0; vl_in = 0; mask_wr = 0; mask_in = 0;
    fill_valid = 0; fill_first = 0; fill_reg = 0; fill_data = 0;
    mask_ref = '1; cur_vl = 64;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(cmd_ready == 1, "R11 cmd_ready", cmd_ready, 1);
    chk(done == 0, "R11 done", done, 0);
    chk(mask_o == '1, "R11 mask", mask_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(vl_o == 64, "R11 length", vl_o, 64);
    for (int r = 0; r < 8; r++) chk(upto_of(r) == 64, "R8 counter after reset", upto_of(r), 64);

    // R1 clamp
    set_vl(100);
    chk(vl_o == 64, "R1 clamp", vl_o, 64);
    set_vl(10);
    chk(vl_o == 10, "R1 store", vl_o, 10);

    fill_vec(1, 1, 3);
    fill_vec(2, 5, 7);
    fill_vec(3, 16'hF000, 1);
    for (int i = 0; i < 64; i++) fill_one(4, i, (i % 3 == 0) ? model[1][i] : 16'(model[1][i] + 1));
    fill_vec(5, 16'h0200, 2);
    fill_vec(6, 16'h0600, 1);
    fill_vec(7, 16'h0700, 1);

    // R3 vector-vector add
    run_op(0, 0, 3, 1, 2, 0, 16, "R3 add vv", 0);
    chk(upto_of(3) == 10, "R8 dst counter", upto_of(3), 10);
    // R3 vector-scalar add
    run_op(1, 0, 3, 1, 0, 16'h0100, 16, "R3 add vs", 0);
    // R3 multiply
    set_vl(5);
    run_op(2, 0, 6, 1, 2, 0, 12, "R3 mul", 0);
    // R4 compare-equal
    set_vl(20);
    run_op(3, 1, 7, 1, 4, 0, 26, "R4 compare", 0);
    chk(mask_o == mask_ref, "R4 mask result", mask_o, mask_ref);
    chk(upto_of(7) == 64, "R4 no register touched", upto_of(7), 64);
    // R5 masked add
    run_op(0, 1, 3, 1, 2, 0, 26, "R5 masked add", 0);
    chk(upto_of(3) == 20, "R8 masked elements counted", upto_of(3), 20);
    // R7 zero length
    set_vl(0);
    run_op(0, 0, 3, 1, 2, 0, 1, "R7 zero length", 0);
    // R2 busy refusal
    set_vl(30);
    run_op(0, 0, 7, 1, 2, 0, 36, "R2 busy op", 1);
    // R12 source equals destination
    set_vl(8);
    run_op(0, 0, 5, 5, 2, 0, 14, "R12 src is dst", 0);

    // R9 chaining behind a partial fill
    set_vl(4);
    fill_one(0, 0, 16'd50);
    for (int i = 1; i < 4; i++) model[0][i] = 16'(50 + i);
    predict(0, 0, 6, 0, 2, 0, "R9 chained add");
    start_cmd(0, 0, 6, 0, 2, 0);
    @(negedge clk); cmd_valid = 0;
    early = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) early = 1;
    end
    chk(!early, "R9 no done before source", early, 0);
    chk(upto_of(6) == 1, "R9 stalled after element 0", upto_of(6), 1);
    for (int i = 1; i < 4; i++) fill_one(0, i, 16'(50 + i));
    chk(upto_of(0) == 4, "R10 fill counter", upto_of(0), 4);
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk); cnt++;
    end
    chk(done == 1, "R9 done after fill", done, 1);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule